// File: doc/BRIEF.md
# Module Base Address Decoder

This block holds two base registers that place internal peripheral spaces into the CPU address map. It also merges the pending interrupt levels of two interrupt controllers. A control-register port writes either register, and a read path shows the stored value of the register it selects.

For each CPU bus cycle, the block turns the address into exactly one of three selects:
- the secondary module window, which is 1 GByte and decoded from address bits [31:30];
- the primary module window, which is 1 MByte and decoded from address bits [31:20];
- a fall-through select that passes the access on to SDRAM or chip-select logic.

A window takes part in the decode only while bit 0 of its register is set. When the secondary window hits, it claims the access ahead of every other decode.

On the interrupt side, the block reports the higher of the two pending levels and which controller supplied it. When both controllers present the same nonzero level, a per-level bit in the secondary register settles the tie.

Top module: `mbd_top`

## Requirements
- R1: After a synchronous reset, both registers read 0. While bus_valid is 1, every access then gives sel_fall.
- R2: A write with cfg_wr=1 takes effect at the next rising edge. cfg_wsel=0 writes the primary register and cfg_wsel=1 writes the secondary register. Reads return only the implemented bits, and all other bits read 0:
  - primary register: bits [31:20] and bit 0;
  - secondary register: bits [31:30], bits [7:1] and bit 0.
- R3: While bit 0 of the primary register is 0, sel_prim is never 1.
- R4: While bit 0 of the primary register is 1 and the secondary window misses, an access whose address bits [31:20] equal register bits [31:20] gives sel_prim. For example, writing 0x10000001 maps the range 0x10000000 to 0x100FFFFF.
- R5: While bit 0 of the secondary register is 1, an access whose address bits [31:30] equal register bits [31:30] gives sel_sec.
- R6: A secondary hit suppresses sel_prim and sel_fall, even when the primary window also matches.
- R7: While bus_valid is 1, exactly one of sel_prim, sel_sec and sel_fall is 1. While bus_valid is 0, all three are 0.
- R8: irq_lvl equals the higher of pri_lvl and sec_lvl. irq_sec is 1 exactly when sec_lvl is strictly higher, unless the tie rule in R9 applies.
- R9: When pri_lvl equals sec_lvl and the level n is nonzero, irq_sec equals bit n of the secondary register. Bits 1 to 7 hold the choice for levels 1 to 7.
- R10: When both levels are 0, irq_lvl is 0 and irq_sec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wsel | input | 1 | Write target: 0 selects primary, 1 selects secondary |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 1 | Read source: 0 selects primary, 1 selects secondary |
| cfg_rdata | output | 32 | Stored value of the selected register |
| bus_valid | input | 1 | CPU bus cycle strobe |
| bus_addr | input | 32 | CPU bus address |
| sel_prim | output | 1 | Primary module window select |
| sel_sec | output | 1 | Secondary module window select |
| sel_fall | output | 1 | Access passes on to SDRAM or chip-select logic |
| pri_lvl | input | 3 | Pending level from the primary controller (0 means none) |
| sec_lvl | input | 3 | Pending level from the secondary controller (0 means none) |
| irq_lvl | output | 3 | Winning level |
| irq_sec | output | 1 | 1 when the secondary controller wins |

## Verification
The selects, the interrupt outputs and the read data are combinational, so they are due in the same cycle as the inputs that produce them. The bench drives its inputs on the falling edge and compares the outputs 1 ns later, before the next rising edge. A register write changes these results only from the cycle after the rising edge that captures it. To match this, the reference model updates its register copies only after that cycle's comparison. The next cycle's comparison is therefore the first one to see the new value.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    localparam int ADDR_W = 32;
    localparam int NLVL   = 7;
    localparam int LVL_W  = $clog2(NLVL + 1);

    typedef struct packed {
        logic prim;
        logic sec;
        logic fall;
    } dec_sel_t;

    typedef enum logic {
        SRC_PRI = 1'b0,
        SRC_SEC = 1'b1
    } irq_src_t;

    // Set the n most significant bits of an address-wide word.
    function automatic logic [ADDR_W-1:0] hi_mask(input int n);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[ADDR_W-1-i] = 1'b1;
        end
        return m;
    endfunction

    // Set bits [hi:lo] of an address-wide word.
    function automatic logic [ADDR_W-1:0] span_mask(input int hi, input int lo);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int i = lo; i <= hi; i++) begin
            m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mbd_regs.sv
module mbd_regs
    import mbd_pkg::*;
#(
    parameter int P1_CMP = 12,
    parameter int P2_CMP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              wsel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              rsel,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] base1_q,
    output logic [ADDR_W-1:0] base2_q
);

    // Implemented bits of each register; every other bit stays 0.
    localparam logic [ADDR_W-1:0] M1 = hi_mask(P1_CMP) | span_mask(0, 0);
    localparam logic [ADDR_W-1:0] M2 = hi_mask(P2_CMP) | span_mask(NLVL, 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base1_q <= '0;
            base2_q <= '0;
        end else if (wr) begin
            if (wsel) begin
                base2_q <= wdata & M2;
            end else begin
                base1_q <= wdata & M1;
            end
        end
    end

    assign rdata = rsel ? base2_q : base1_q;

    a_r2_prim_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr && !wsel) |=> (base1_q == ($past(wdata) & M1)));

    a_r2_sec_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr && wsel) |=> (base2_q == ($past(wdata) & M2)));

    a_r2_no_write_holds: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(base1_q) && $stable(base2_q)));

endmodule

// File: rtl/mbd_addr_decode.sv
module mbd_addr_decode
    import mbd_pkg::*;
#(
    parameter int P1_CMP = 12,
    parameter int P2_CMP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] base1,
    input  logic [ADDR_W-1:0] base2,
    output dec_sel_t          sel
);

    logic hit2;
    logic hit1;

    // The secondary window is checked first: a hit there blocks every other decode.
    assign hit2 = bus_valid && base2[0]
               && (bus_addr[ADDR_W-1 -: P2_CMP] == base2[ADDR_W-1 -: P2_CMP]);

    assign hit1 = bus_valid && !hit2 && base1[0]
               && (bus_addr[ADDR_W-1 -: P1_CMP] == base1[ADDR_W-1 -: P1_CMP]);

    always_comb begin
        sel      = '0;
        sel.sec  = hit2;
        sel.prim = hit1;
        sel.fall = bus_valid && !hit2 && !hit1;
    end

    a_r7_onehot_when_valid: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> $onehot({sel.prim, sel.sec, sel.fall}));

    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (sel == '0));

    a_r3_invalid_never_selects: assert property (@(posedge clk) disable iff (rst)
        !base1[0] |-> !sel.prim);

    a_r6_sec_suppresses_others: assert property (@(posedge clk) disable iff (rst)
        sel.sec |-> (!sel.prim && !sel.fall));

    a_r5_sec_needs_valid_bit: assert property (@(posedge clk) disable iff (rst)
        sel.sec |-> base2[0]);

endmodule

// File: rtl/mbd_irq_merge.sv
module mbd_irq_merge
    import mbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] pri_lvl,
    input  logic [LVL_W-1:0] sec_lvl,
    input  logic [NLVL:1]    tie_sec,
    output logic [LVL_W-1:0] win_lvl,
    output irq_src_t         win_src
);

    // Level 0 never requests, so its slot in the extended vector is a fixed 0.
    logic [NLVL:0] tie_ext;

    assign tie_ext = {tie_sec, 1'b0};

    always_comb begin
        if (pri_lvl > sec_lvl) begin
            win_lvl = pri_lvl;
            win_src = SRC_PRI;
        end else if (sec_lvl > pri_lvl) begin
            win_lvl = sec_lvl;
            win_src = SRC_SEC;
        end else begin
            win_lvl = pri_lvl;
            win_src = tie_ext[pri_lvl] ? SRC_SEC : SRC_PRI;
        end
    end

    a_r8_level_is_max: assert property (@(posedge clk) disable iff (rst)
        (win_lvl >= pri_lvl) && (win_lvl >= sec_lvl)
        && ((win_lvl == pri_lvl) || (win_lvl == sec_lvl)));

    a_r8_source_holds_level: assert property (@(posedge clk) disable iff (rst)
        (win_src == SRC_SEC) |-> (sec_lvl == win_lvl));

    a_r10_idle_primary: assert property (@(posedge clk) disable iff (rst)
        ((pri_lvl == '0) && (sec_lvl == '0)) |-> ((win_lvl == '0) && (win_src == SRC_PRI)));

endmodule

// File: rtl/mbd_top.sv
module mbd_top
    import mbd_pkg::*;
#(
    parameter int P1_CMP = 12,
    parameter int P2_CMP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_wsel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cfg_rsel,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              sel_prim,
    output logic              sel_sec,
    output logic              sel_fall,
    input  logic [LVL_W-1:0]  pri_lvl,
    input  logic [LVL_W-1:0]  sec_lvl,
    output logic [LVL_W-1:0]  irq_lvl,
    output logic              irq_sec
);

    logic [ADDR_W-1:0] base1_q;
    logic [ADDR_W-1:0] base2_q;
    dec_sel_t          sel;
    irq_src_t          src;

    mbd_regs #(.P1_CMP(P1_CMP), .P2_CMP(P2_CMP)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .wsel    (cfg_wsel),
        .wdata   (cfg_wdata),
        .rsel    (cfg_rsel),
        .rdata   (cfg_rdata),
        .base1_q (base1_q),
        .base2_q (base2_q)
    );

    mbd_addr_decode #(.P1_CMP(P1_CMP), .P2_CMP(P2_CMP)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .base1     (base1_q),
        .base2     (base2_q),
        .sel       (sel)
    );

    mbd_irq_merge u_irq (
        .clk     (clk),
        .rst     (rst),
        .pri_lvl (pri_lvl),
        .sec_lvl (sec_lvl),
        .tie_sec (base2_q[NLVL:1]),
        .win_lvl (irq_lvl),
        .win_src (src)
    );

    assign sel_prim = sel.prim;
    assign sel_sec  = sel.sec;
    assign sel_fall = sel.fall;
    assign irq_sec  = (src == SRC_SEC);

endmodule

// File: tb/sim_mbd_top.sv
`timescale 1ns/1ps
module sim_mbd_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_wsel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rsel = 1'b0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        sel_prim;
    logic        sel_sec;
    logic        sel_fall;
    logic [2:0]  pri_lvl = '0;
    logic [2:0]  sec_lvl = '0;
    logic [2:0]  irq_lvl;
    logic        irq_sec;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done    = 0;

    // Reference copies of the two registers, held as implemented-bit values.
    logic [31:0] m_b1 = '0;
    logic [31:0] m_b2 = '0;

    always #2.5 clk = ~clk;

    mbd_top u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wsel  (cfg_wsel),
        .cfg_wdata (cfg_wdata),
        .cfg_rsel  (cfg_rsel),
        .cfg_rdata (cfg_rdata),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .sel_prim  (sel_prim),
        .sel_sec   (sel_sec),
        .sel_fall  (sel_fall),
        .pri_lvl   (pri_lvl),
        .sec_lvl   (sec_lvl),
        .irq_lvl   (irq_lvl),
        .irq_sec   (irq_sec)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, compare 1 ns later, then let the rising edge capture.
    task automatic step(input logic wr, input logic wsel, input logic [31:0] wd,
                        input logic rsel, input logic bv, input logic [31:0] a,
                        input logic [2:0] pl, input logic [2:0] sl, input string tag);
        logic       h2, h1;
        logic [2:0] el;
        logic       es;
        string      itag;
        @(negedge clk);
        cfg_wr = wr; cfg_wsel = wsel; cfg_wdata = wd; cfg_rsel = rsel;
        bus_valid = bv; bus_addr = a; pri_lvl = pl; sec_lvl = sl;
        #1;
        h2 = bv && m_b2[0] && (a[31:30] == m_b2[31:30]);
        h1 = bv && !h2 && m_b1[0] && (a[31:20] == m_b1[31:20]);
        chk(tag, "sel_sec",  sel_sec,  h2);
        chk(tag, "sel_prim", sel_prim, h1);
        chk(tag, "sel_fall", sel_fall, bv && !h1 && !h2);
        chk("R2", "cfg_rdata", cfg_rdata, rsel ? m_b2 : m_b1);
        if (pl > sl) begin
            el = pl; es = 1'b0; itag = "R8";
        end else if (sl > pl) begin
            el = sl; es = 1'b1; itag = "R8";
        end else if (pl == 0) begin
            el = 0; es = 1'b0; itag = "R10";
        end else begin
            el = pl; es = m_b2[pl]; itag = "R9";
        end
        chk(itag, "irq_lvl", irq_lvl, el);
        chk(itag, "irq_sec", irq_sec, es);
        @(posedge clk);
        if (wr && !rst) begin
            if (wsel) m_b2 = wd & 32'hC000_00FF;
            else      m_b1 = wd & 32'hFFF0_0001;
        end
    endtask

    task automatic wr_reg(input logic wsel, input logic [31:0] wd, input string tag);
        step(1'b1, wsel, wd, wsel, 1'b0, '0, '0, '0, tag);
    endtask

    task automatic acc(input logic [31:0] a, input string tag);
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, a, '0, '0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset contents and fall-through decode
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, 32'h1000_0000, '0, '0, "R1");
        step(1'b0, 1'b0, '0, 1'b1, 1'b1, 32'h0000_0000, '0, '0, "R1");
        step(1'b0, 1'b0, '0, 1'b1, 1'b1, 32'hC000_0000, '0, '0, "R1");
        // R3: a base with the valid bit clear never selects
        wr_reg(1'b0, 32'h1000_0000, "R3");
        acc(32'h1000_0040, "R3");
        acc(32'h1000_0000, "R3");
        // R4: the window of 0x10000001 and its edges
        wr_reg(1'b0, 32'h1000_0001, "R4");
        acc(32'h1000_0000, "R4");
        acc(32'h100F_FFFF, "R4");
        acc(32'h1010_0000, "R4");
        acc(32'h0FFF_FFFF, "R4");
        // R2: unimplemented bits read as 0
        wr_reg(1'b0, 32'hFFFF_FFFF, "R2");
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, '0, "R2");
        wr_reg(1'b1, 32'hFFFF_FFFF, "R2");
        step(1'b0, 1'b0, '0, 1'b1, 1'b0, '0, '0, '0, "R2");
        // R5 and R6: secondary window at base 0 overlapping the primary window
        wr_reg(1'b0, 32'h1000_0001, "R6");
        wr_reg(1'b1, 32'h0000_0001, "R5");
        acc(32'h1000_0000, "R6");
        acc(32'h3FFF_FFFF, "R5");
        acc(32'h4000_0000, "R5");
        wr_reg(1'b0, 32'h5000_0001, "R4");
        acc(32'h5000_0000, "R4");
        wr_reg(1'b1, 32'h4000_0001, "R6");
        acc(32'h5000_0000, "R6");
        wr_reg(1'b1, 32'h4000_0000, "R5");
        acc(32'h5000_0000, "R5");
        // R7: an idle bus drives no select
        for (int i = 0; i < 20; i++)
            step(1'b0, 1'b0, '0, 1'b0, 1'b0, $urandom, '0, '0, "R7");
        // R8, R9, R10: every level pair under three tie patterns
        foreach (m_b1[k]) begin end
        for (int p = 0; p < 3; p++) begin
            wr_reg(1'b1, (p == 0) ? 32'h0 : (p == 1) ? 32'hFE : 32'hAA, "R9");
            for (int x = 0; x < 8; x++)
                for (int y = 0; y < 8; y++)
                    step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, x[2:0], y[2:0], "R8");
        end
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[2], {r[31:30], $urandom % 4 == 0 ? 10'h100 : r[29:20], 12'h0, r[7:0]},
                 r[3], r[4] | r[5], {r[31:30] ^ {r[8], 1'b0}, 10'h100 ^ {9'h0, r[9]}, $urandom % 2 ? 20'h0 : r[19:0]},
                 r[12:10], r[15:13], "R7");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            misses++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule